// File: doc/BRIEF.md
# Byte/Word Arithmetic-Logic Unit with Condition Flags

This unit performs one arithmetic or logical operation on either 8-bit or 16-bit operands each time a start strobe is given. The caller provides the operation code, the width select, two operands and the present condition flags. On the next clock edge the unit registers the result, a six-bit updated flag vector, a one-cycle done pulse and a destination write enable. The caller keeps the flag state itself and feeds it back in with the next operation.

The arithmetic set is add, add with carry-in, subtract and subtract with borrow-in. All four use two's complement. The logical set is AND, OR, XOR, complement and test. A single flag bit does two jobs. After arithmetic it holds signed overflow. After a byte logical operation it holds even parity. A word logical operation leaves it alone. The decimal-direction and nibble-carry flags are written only by byte arithmetic, so that a later decimal correction step can use them.

The flag vector bit positions are fixed: bit 0 carry (C), bit 1 zero (Z), bit 2 sign (S), bit 3 parity/overflow (PV), bit 4 decimal direction (D), bit 5 half carry (H). The operation codes are listed in the requirements.

Top module: `flag_alu`

## Requirements
- R1: While reset is active, and until the internal release completes, `result_o`, `flags_o`, `done_o` and `wr_en_o` are all zero.
- R2: When `start_i` is high at a clock edge, `done_o` is high after that edge and the new result and flags appear at the same edge. When `start_i` is low, `done_o` and `wr_en_o` go low and `result_o` and `flags_o` hold their values.
- R3: Code 0 adds, code 1 adds plus C, code 2 subtracts (a minus b), and code 3 subtracts b and C. With `byte_i` high, only bits 7:0 of each operand are used and `result_o[15:8]` is zero.
- R4: After arithmetic, C (bit 0) is the carry out of the top bit of the selected width for add. For subtract it is the borrow into that bit.
- R5: After add, PV (bit 3) is set when both operands share a sign and the result's sign differs. After subtract, PV is set when the operand signs differ and the result's sign differs from a's.
- R6: For every defined operation, Z (bit 1) is set exactly when the width-limited result is zero, and S (bit 2) equals its top bit.
- R7: Byte arithmetic writes D (bit 4) as 0 for add and 1 for subtract, and writes H (bit 5) as the carry out of bit 3 (add) or the borrow into bit 3 (subtract). Word arithmetic leaves D and H equal to `flags_i`.
- R8: Code 4 is AND, 5 is OR, 6 is XOR, 7 complements a, and 8 is test. Logical operations copy C, D and H from `flags_i`.
- R9: A byte logical operation sets PV to 1 when the 8-bit result has an even number of ones and to 0 otherwise. A word logical operation copies PV from `flags_i`.
- R10: Test (code 8) updates Z, S and PV from operand a alone, drives `wr_en_o` low and leaves `result_o` unchanged.
- R11: Codes 9 to 15 pulse `done_o`, copy `flags_i` to `flags_o`, drive `wr_en_o` low and leave `result_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, one operation per high cycle |
| op_i | input | 4 | Operation code |
| byte_i | input | 1 | 1 selects 8-bit operation, 0 selects 16-bit |
| a_i | input | 16 | Destination operand |
| b_i | input | 16 | Source operand |
| flags_i | input | 6 | Current flags {H,D,PV,S,Z,C} |
| result_o | output | 16 | Registered result |
| flags_o | output | 6 | Registered updated flags |
| done_o | output | 1 | One-cycle completion pulse |
| wr_en_o | output | 1 | Destination write enable for this result |

## Verification
Some properties are checked on every cycle: the strobe-to-done timing, holding of outputs while idle, the zero upper byte in byte mode, the agreement of Z with the written result, and the flags that each operation class must pass through unchanged (D/H for word arithmetic, C/D/H for logic, PV for word logic, all flags for undefined codes). The no-write behaviour of test is also checked every cycle. The actual values of carry, borrow, overflow, half carry and parity are shown only by the bench. It compares random and directed operations against its own model, including the 225+64 carry, the 120+105 overflow and the borrow chains through carry-in.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  localparam int FLAG_W = 6;
  localparam int OP_W   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_COM  = 4'd7,
    OP_TEST = 4'd8
  } alu_op_e;

  // bit 0 = c ... bit 5 = h
  typedef struct packed {
    logic h;
    logic d;
    logic pv;
    logic s;
    logic z;
    logic c;
  } flags_t;

endpackage

// File: rtl/flag_alu_addsub.sv
module flag_alu_addsub #(
  parameter int W   = 16,
  parameter int NIB = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         carry,
  output logic         ovf,
  output logic         half
);

  logic [W-1:0] b_eff;
  logic         c_eff;
  logic [W:0]   full;
  logic [NIB:0] low;

  always_comb begin
    // a - b - c is formed as a + ~b + !c
    b_eff = sub ? ~b : b;
    c_eff = sub ? ~cin : cin;
    full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
    low   = {1'b0, a[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + {{NIB{1'b0}}, c_eff};
    sum   = full[W-1:0];
    carry = sub ? ~full[W] : full[W];
    half  = sub ? ~low[NIB] : low[NIB];
    ovf   = (a[W-1] == b_eff[W-1]) && (full[W-1] != a[W-1]);
  end

endmodule

// File: rtl/flag_alu_logic.sv
module flag_alu_logic
  import flag_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  output logic [W-1:0]    r
);

  always_comb begin
    unique case (op)
      OP_AND:  r = a & b;
      OP_OR:   r = a | b;
      OP_XOR:  r = a ^ b;
      OP_COM:  r = ~a;
      OP_TEST: r = a | {W{1'b0}};
      default: r = '0;
    endcase
  end

endmodule

// File: rtl/flag_alu_select.sv
module flag_alu_select
  import flag_alu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic [OP_W-1:0]   op,
  input  logic              byte_sel,
  input  flags_t            fin,
  input  logic [BYTE_W-1:0] ar_b_sum,
  input  logic              ar_b_carry,
  input  logic              ar_b_ovf,
  input  logic              ar_b_half,
  input  logic [DATA_W-1:0] ar_w_sum,
  input  logic              ar_w_carry,
  input  logic              ar_w_ovf,
  input  logic [BYTE_W-1:0] lg_b,
  input  logic [DATA_W-1:0] lg_w,
  output logic [DATA_W-1:0] res,
  output flags_t            fout,
  output logic              we
);

  localparam int PAD_W = DATA_W - BYTE_W;

  logic is_arith;
  logic is_logic;
  logic is_sub;
  logic [DATA_W-1:0] ar_res;
  logic [DATA_W-1:0] lg_res;
  logic ar_carry;
  logic ar_ovf;

  always_comb begin
    is_arith = (op == OP_ADD) || (op == OP_ADC) || (op == OP_SUB) || (op == OP_SBC);
    is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) ||
               (op == OP_COM) || (op == OP_TEST);
    is_sub   = (op == OP_SUB) || (op == OP_SBC);
    ar_res   = byte_sel ? {{PAD_W{1'b0}}, ar_b_sum} : ar_w_sum;
    lg_res   = byte_sel ? {{PAD_W{1'b0}}, lg_b} : lg_w;
    ar_carry = byte_sel ? ar_b_carry : ar_w_carry;
    ar_ovf   = byte_sel ? ar_b_ovf : ar_w_ovf;
  end

  always_comb begin
    fout = fin;
    res  = '0;
    we   = 1'b0;
    if (is_arith) begin
      res     = ar_res;
      we      = 1'b1;
      fout.c  = ar_carry;
      fout.z  = (ar_res == '0);
      fout.s  = byte_sel ? ar_b_sum[BYTE_W-1] : ar_w_sum[DATA_W-1];
      fout.pv = ar_ovf;
      if (byte_sel) begin
        fout.d = is_sub;
        fout.h = ar_b_half;
      end
    end else if (is_logic) begin
      res    = lg_res;
      we     = (op != OP_TEST);
      fout.z = (lg_res == '0);
      fout.s = byte_sel ? lg_b[BYTE_W-1] : lg_w[DATA_W-1];
      if (byte_sel) begin
        fout.pv = ~(^lg_b);
      end
    end
  end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [3:0]        op_i,
  input  logic              byte_i,
  input  logic [15:0]       a_i,
  input  logic [15:0]       b_i,
  input  logic [5:0]        flags_i,
  output logic [15:0]       result_o,
  output logic [5:0]        flags_o,
  output logic              done_o,
  output logic              wr_en_o
);

  localparam int NIB_W = BYTE_W / 2;

  // reset: asserted at once, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic              sub_sel;
  logic              cin_sel;
  logic [BYTE_W-1:0] ab_sum;
  logic              ab_carry, ab_ovf, ab_half;
  logic [DATA_W-1:0] aw_sum;
  logic              aw_carry, aw_ovf, aw_half;
  logic [BYTE_W-1:0] lb_res;
  logic [DATA_W-1:0] lw_res;
  logic [DATA_W-1:0] new_res;
  flags_t            new_flags;
  logic              new_we;

  always_comb begin
    sub_sel = (op_i == OP_SUB) || (op_i == OP_SBC);
    cin_sel = ((op_i == OP_ADC) || (op_i == OP_SBC)) && flags_i[0];
  end

  flag_alu_addsub #(.W(BYTE_W), .NIB(NIB_W)) u_as_byte (
    .a(a_i[BYTE_W-1:0]), .b(b_i[BYTE_W-1:0]), .sub(sub_sel), .cin(cin_sel),
    .sum(ab_sum), .carry(ab_carry), .ovf(ab_ovf), .half(ab_half)
  );

  flag_alu_addsub #(.W(DATA_W), .NIB(NIB_W)) u_as_word (
    .a(a_i), .b(b_i), .sub(sub_sel), .cin(cin_sel),
    .sum(aw_sum), .carry(aw_carry), .ovf(aw_ovf), .half(aw_half)
  );

  flag_alu_logic #(.W(BYTE_W)) u_lg_byte (
    .op(op_i), .a(a_i[BYTE_W-1:0]), .b(b_i[BYTE_W-1:0]), .r(lb_res)
  );

  flag_alu_logic #(.W(DATA_W)) u_lg_word (
    .op(op_i), .a(a_i), .b(b_i), .r(lw_res)
  );

  flag_alu_select #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_sel (
    .op(op_i), .byte_sel(byte_i), .fin(flags_t'(flags_i)),
    .ar_b_sum(ab_sum), .ar_b_carry(ab_carry), .ar_b_ovf(ab_ovf), .ar_b_half(ab_half),
    .ar_w_sum(aw_sum), .ar_w_carry(aw_carry), .ar_w_ovf(aw_ovf),
    .lg_b(lb_res), .lg_w(lw_res),
    .res(new_res), .fout(new_flags), .we(new_we)
  );

  // word half carry is not a flag source; fold it into nothing observable
  logic unused_half;
  assign unused_half = aw_half;

  // next state
  logic [DATA_W-1:0] res_q, res_d;
  logic [5:0]        flg_q, flg_d;
  logic              done_q, done_d;
  logic              we_q, we_d;
  logic              upd_en;

  always_comb begin
    upd_en = start_i;
    done_d = start_i;
    we_d   = start_i && new_we;
    res_d  = (start_i && new_we) ? new_res : res_q;
    flg_d  = start_i ? new_flags : flg_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_q  <= '0;
      flg_q  <= '0;
      done_q <= 1'b0;
      we_q   <= 1'b0;
    end else begin
      done_q <= done_d;
      we_q   <= we_d;
      if (upd_en) begin
        res_q <= res_d;
        flg_q <= flg_d;
      end
    end
  end

  assign result_o = res_q;
  assign flags_o  = flg_q;
  assign done_o   = done_q;
  assign wr_en_o  = we_q;

endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk (
  input logic        clk,
  input logic        rst_sync_n,
  input logic        start_i,
  input logic [3:0]  op_i,
  input logic        byte_i,
  input logic [5:0]  flags_i,
  input logic [15:0] result_o,
  input logic [5:0]  flags_o,
  input logic        done_o,
  input logic        wr_en_o
);

  logic is_ar, is_lg;
  assign is_ar = (op_i <= 4'd3);
  assign is_lg = (op_i >= 4'd4) && (op_i <= 4'd8);

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_sync_n |-> (result_o == 16'h0) && (flags_o == 6'h0) && !done_o && !wr_en_o);

  a_r2_done_follows_start: assert property (@(posedge clk) disable iff (!rst_sync_n)
    start_i |=> done_o);

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !start_i |=> !done_o && !wr_en_o && $stable(result_o) && $stable(flags_o));

  a_r3_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    start_i && byte_i && is_ar |=> result_o[15:8] == 8'h00);

  a_r6_zero_matches: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o && wr_en_o |-> flags_o[1] == (result_o == 16'h0));

  a_r7_word_arith_dh: assert property (@(posedge clk) disable iff (!rst_sync_n)
    start_i && !byte_i && is_ar |=> flags_o[5:4] == $past(flags_i[5:4]));

  a_r8_logic_keeps_cdh: assert property (@(posedge clk) disable iff (!rst_sync_n)
    start_i && is_lg |=> (flags_o[0] == $past(flags_i[0])) &&
                         (flags_o[5:4] == $past(flags_i[5:4])));

  a_r9_word_logic_pv: assert property (@(posedge clk) disable iff (!rst_sync_n)
    start_i && !byte_i && is_lg |=> flags_o[3] == $past(flags_i[3]));

  a_r10_test_no_write: assert property (@(posedge clk) disable iff (!rst_sync_n)
    start_i && (op_i == 4'd8) |=> !wr_en_o && $stable(result_o));

  a_r11_undefined_code: assert property (@(posedge clk) disable iff (!rst_sync_n)
    start_i && (op_i > 4'd8) |=> (flags_o == $past(flags_i)) && !wr_en_o &&
                                 $stable(result_o));

endmodule

bind flag_alu flag_alu_chk u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .start_i(start_i), .op_i(op_i),
  .byte_i(byte_i), .flags_i(flags_i), .result_o(result_o), .flags_o(flags_o),
  .done_o(done_o), .wr_en_o(wr_en_o)
);

// File: tb/tb_flag_alu.sv
module tb_flag_alu;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [3:0]  op_i;
  logic        byte_i;
  logic [15:0] a_i, b_i;
  logic [5:0]  flags_i;
  logic [15:0] result_o;
  logic [5:0]  flags_o;
  logic        done_o, wr_en_o;

  int checks = 0;
  int fails  = 0;
  logic [15:0] exp_res = 16'h0;
  logic [5:0]  exp_flg = 6'h0;
  bit          finished = 0;

  always #2 clk = ~clk;

  flag_alu dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .byte_i(byte_i),
    .a_i(a_i), .b_i(b_i), .flags_i(flags_i), .result_o(result_o),
    .flags_o(flags_o), .done_o(done_o), .wr_en_o(wr_en_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // returns {we, result, flags}
  function automatic logic [22:0] model(input int op, input bit bw,
      input logic [15:0] a, input logic [15:0] b, input logic [5:0] fin,
      input logic [15:0] held);
    int w, mask, av, bv, cin, full, sa, sb, sr, rr;
    logic [15:0] r;
    logic [5:0]  f;
    bit we;
    w = bw ? 8 : 16;
    mask = bw ? 255 : 65535;
    av = int'(a) & mask;
    bv = int'(b) & mask;
    f = fin; r = held; we = 0;
    if (op <= 3) begin
      cin = (op == 1 || op == 3) ? int'(fin[0]) : 0;
      if (op < 2) full = av + bv + cin;
      else        full = av - bv - cin;
      rr = full & mask;
      sa = (av >> (w-1)) & 1; sb = (bv >> (w-1)) & 1; sr = (rr >> (w-1)) & 1;
      f[0] = (op < 2) ? (full > mask) : (full < 0);
      f[1] = (rr == 0);
      f[2] = sr[0];
      f[3] = (op < 2) ? (sa == sb && sr != sa) : (sa != sb && sr != sa);
      if (bw) begin
        f[4] = (op >= 2);
        f[5] = (op < 2) ? (((av & 15) + (bv & 15) + cin) > 15)
                        : (((av & 15) - (bv & 15) - cin) < 0);
      end
      r = rr[15:0]; we = 1;
    end else if (op <= 8) begin
      case (op)
        4: rr = av & bv;
        5: rr = av | bv;
        6: rr = av ^ bv;
        7: rr = (~av) & mask;
        default: rr = av;
      endcase
      f[1] = (rr == 0);
      f[2] = ((rr >> (w-1)) & 1) != 0;
      if (bw) f[3] = ~(^rr[7:0]);
      if (op != 8) begin r = rr[15:0]; we = 1; end
    end
    return {we, r, f};
  endfunction

  task automatic do_op(input int op, input bit bw, input logic [15:0] a,
                       input logic [15:0] b, input logic [5:0] fin, input string req);
    logic [22:0] e;
    e = model(op, bw, a, b, fin, exp_res);
    op_i = op[3:0]; byte_i = bw; a_i = a; b_i = b; flags_i = fin; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    exp_res = e[21:6]; exp_flg = e[5:0];
    check(done_o == 1'b1, {req, " R2 done"}, done_o, 1);
    check(wr_en_o == e[22], {req, " wr_en"}, wr_en_o, e[22]);
    check(result_o == exp_res, {req, " result"}, result_o, exp_res);
    check(flags_o == exp_flg, {req, " flags"}, flags_o, exp_flg);
  endtask

  task automatic idle_check();
    @(negedge clk);
    check(!done_o && !wr_en_o, "R2 idle pulses low", {done_o, wr_en_o}, 0);
    check(result_o == exp_res && flags_o == exp_flg, "R2 idle hold",
          {result_o, flags_o}, {exp_res, exp_flg});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
    end
  end

  initial begin
    int seed;
    rst_n = 1'b0; start_i = 1'b0; op_i = '0; byte_i = 1'b0;
    a_i = '0; b_i = '0; flags_i = '0;
    repeat (3) @(negedge clk);
    check(result_o == 0 && flags_o == 0 && !done_o && !wr_en_o, "R1 reset state",
          {result_o, flags_o, done_o, wr_en_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(result_o == 0 && !done_o, "R1 after release", {result_o, done_o}, 0);

    // directed corner cases
    do_op(0, 1, 16'd225, 16'd64, 6'h00, "R3 R4 byte add carry");
    do_op(0, 1, 16'd120, 16'd105, 6'h00, "R5 R7 byte add overflow halfcarry");
    do_op(1, 1, 16'h00FF, 16'h0000, 6'h01, "R4 R6 byte adc wraps to zero");
    do_op(2, 1, 16'h0010, 16'h0001, 6'h00, "R7 byte sub half borrow");
    do_op(3, 1, 16'h0000, 16'h0000, 6'h01, "R4 byte sbc borrow");
    do_op(2, 1, 16'h0080, 16'h0001, 6'h00, "R5 byte sub overflow");
    do_op(0, 0, 16'h7FFF, 16'h0001, 6'h30, "R5 R7 word add overflow keeps DH");
    do_op(3, 0, 16'h1234, 16'h1234, 6'h01, "R4 word sbc borrow");
    do_op(1, 0, 16'hFFFF, 16'h0000, 6'h01, "R6 word adc zero");
    idle_check();
    do_op(4, 1, 16'h0F0F, 16'h00F3, 6'h37, "R8 R9 byte and parity");
    do_op(5, 0, 16'h8000, 16'h0001, 6'h08, "R8 R9 word or keeps PV");
    do_op(6, 1, 16'h00AA, 16'h0055, 6'h00, "R8 R9 byte xor");
    do_op(7, 0, 16'hFFFF, 16'h0000, 6'h00, "R8 word complement zero");
    do_op(8, 1, 16'h0081, 16'hFFFF, 6'h3F, "R10 byte test no write");
    do_op(8, 0, 16'h0000, 16'h0000, 6'h00, "R10 word test zero");
    do_op(9, 0, 16'h1111, 16'h2222, 6'h2A, "R11 undefined code");
    do_op(15, 1, 16'h00FF, 16'h00FF, 6'h15, "R11 undefined code max");
    idle_check();

    // random mix
    seed = $urandom(32'h5EED);
    for (int i = 0; i < 3000; i++) begin
      int op;
      op = ($urandom % 8 == 0) ? int'($urandom % 16) : int'($urandom % 9);
      do_op(op, 1'($urandom), 16'($urandom), 16'($urandom), 6'($urandom),
            "R3 R4 R5 R6 R7 R8 R9 R10 R11 random");
      if ($urandom % 10 == 0) idle_check();
    end

    finished = 1;
    summary();
  end

endmodule